// File: doc/BRIEF.md
# Clock Output Gating Controller

This block decides, for each output of a clock generator, whether the output toggles, is parked at a driven level, or is released to high impedance. There are two groups of outputs. The processor group can be halted by an active-low stop pin. The serial-link group can be halted by either of two active-low request pins. Per-output mask bits select which outputs each pin may halt. Power-down and the per-output enable bits override both pins. For every stop source there is a drive-mode bit that chooses whether a halted output stays driven or floats.

The stop pins and the power-down input are asynchronous, so each one passes through a two-stage synchroniser. Every output has a lane register that holds its current mode. That register may change only on a clock edge at which the output's own clock level (its `*_lvl` input) is low. A stop or a restart therefore never cuts a high phase short.

The register bits come from a register file outside this block and are sampled directly. The free-running output clocks are presented as levels in the same clock domain. The block returns per-output run and output-enable flags, together with the gated true and complement levels.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: During reset and right after it, every lane is in the running mode, so every `*_run` and every `*_oe` bit reads 1.
- R2: A cleared enable bit puts its output in high impedance (`oe`=0, `run`=0), whatever the pins, masks, power-down or drive modes say.
- R3: While `cpu_stop_n` is low, a processor output whose `cpu_stop_mask` bit is 1 halts. An output whose mask bit is 0 keeps running.
- R4: `cpu_stop_float` selects what a processor output halted by the stop pin does: 0 keeps it driven (`oe`=1) and 1 floats it (`oe`=0).
- R5: A serial-link output halts when `clkreq_n[0]` is low and its `req0_mask` bit is 1, or when `clkreq_n[1]` is low and its `req1_mask` bit is 1. With both mask bits 0 it runs no matter what the request pins do.
- R6: `req_float` selects what a serial-link output halted by a request pin does: 0 keeps it driven and 1 floats it.
- R7: While `pwr_dn` is 1, every enabled output halts whatever the pins say. `cpu_pd_float` sets the mode for the processor group and `src_pd_float` sets it for the serial-link group, with 0 meaning driven and 1 meaning float.
- R8: A lane's mode changes only on a rising edge at which its `*_lvl` input is 0. While that input stays 1, `run` and `oe` hold.
- R9: A running lane gives true = lvl and complement = not lvl. A lane that is not running gives true = 0 and complement = 1.
- R10: A change on a stop, request or power-down pin reaches the lane after two synchroniser edges. With lvl held at 0, `run` is unchanged after the second rising edge that follows the pin change and has taken its new value after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; output clock levels are sampled in this domain |
| rst | input | 1 | Synchronous active-high reset |
| cpu_lvl | input | NCPU | Free-running level of each processor output clock |
| src_lvl | input | NSRC | Free-running level of each serial-link output clock |
| cpu_en | input | NCPU | Processor output enable bits |
| src_en | input | NSRC | Serial-link output enable bits |
| cpu_stop_mask | input | NCPU | 1 lets the stop pin halt that processor output |
| req0_mask | input | NSRC | 1 lets request pin 0 halt that serial-link output |
| req1_mask | input | NSRC | 1 lets request pin 1 halt that serial-link output |
| cpu_stop_float | input | 1 | Stop-pin drive mode: 0 driven, 1 float |
| req_float | input | 1 | Request-pin drive mode: 0 driven, 1 float |
| cpu_pd_float | input | 1 | Power-down drive mode for the processor group |
| src_pd_float | input | 1 | Power-down drive mode for the serial-link group |
| cpu_stop_n | input | 1 | Asynchronous active-low processor stop pin |
| clkreq_n | input | 2 | Asynchronous active-low request pins |
| pwr_dn | input | 1 | Asynchronous active-high power-down |
| cpu_run | output | NCPU | Processor output toggling |
| cpu_oe | output | NCPU | Processor output driven (0 = high impedance) |
| cpu_t | output | NCPU | Gated true level, processor group |
| cpu_c | output | NCPU | Gated complement level, processor group |
| src_run | output | NSRC | Serial-link output toggling |
| src_oe | output | NSRC | Serial-link output driven (0 = high impedance) |
| src_t | output | NSRC | Gated true level, serial-link group |
| src_c | output | NSRC | Gated complement level, serial-link group |

## Verification
A table of settings exercises the priority chain from several sides:
- mixed masks with the stop pin low separate masked outputs from free-running ones;
- each request pin on its own, then both with masks clear, shows that the two pins are ORed and that the masks gate them;
- power-down with opposite group modes shows that each group takes its own mode bit;
- cleared enables under power-down show that the enable wins over everything.

Directed steps then hold the clock level high during a stop to prove the update waits for the low phase. They check the parked true and complement levels, and they count edges after a pin change to pin the synchroniser latency.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;

    // Lane modes: toggling, parked but driven, released to high impedance
    typedef enum logic [1:0] {
        LANE_RUN  = 2'd0,
        LANE_PARK = 2'd1,
        LANE_HIZ  = 2'd2
    } lane_mode_e;

    // Priority: enable clear > power-down > pin stop > run
    function automatic lane_mode_e resolve_mode(
        input logic en,
        input logic pd,
        input logic pd_float,
        input logic halted,
        input logic halt_float
    );
        if (!en)
            return LANE_HIZ;
        if (pd)
            return pd_float ? LANE_HIZ : LANE_PARK;
        if (halted)
            return halt_float ? LANE_HIZ : LANE_PARK;
        return LANE_RUN;
    endfunction

endpackage

// File: rtl/clkout_gate_sync.sv
module clkout_gate_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++)
                stg[k] <= IDLE;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++)
                stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clkout_gate_lane.sv
module clkout_gate_lane
    import clkout_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    input  lane_mode_e want,
    output logic       run,
    output logic       oe,
    output logic       pt,
    output logic       pc
);
    lane_mode_e mode_q;

    // The mode moves only while the output clock sits in its low phase
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= LANE_RUN;
        else if (!lvl)
            mode_q <= want;
    end

    assign run = (mode_q == LANE_RUN);
    assign oe  = (mode_q != LANE_HIZ);
    assign pt  = run & lvl;
    assign pc  = ~(run & lvl);
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
    import clkout_gate_pkg::*;
#(
    parameter int NCPU        = 3,
    parameter int NSRC        = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCPU-1:0] cpu_lvl,
    input  logic [NSRC-1:0] src_lvl,
    input  logic [NCPU-1:0] cpu_en,
    input  logic [NSRC-1:0] src_en,
    input  logic [NCPU-1:0] cpu_stop_mask,
    input  logic [NSRC-1:0] req0_mask,
    input  logic [NSRC-1:0] req1_mask,
    input  logic            cpu_stop_float,
    input  logic            req_float,
    input  logic            cpu_pd_float,
    input  logic            src_pd_float,
    input  logic            cpu_stop_n,
    input  logic [1:0]      clkreq_n,
    input  logic            pwr_dn,
    output logic [NCPU-1:0] cpu_run,
    output logic [NCPU-1:0] cpu_oe,
    output logic [NCPU-1:0] cpu_t,
    output logic [NCPU-1:0] cpu_c,
    output logic [NSRC-1:0] src_run,
    output logic [NSRC-1:0] src_oe,
    output logic [NSRC-1:0] src_t,
    output logic [NSRC-1:0] src_c
);
    localparam int PIN_W = 4;

    // Pin bundle: {pwr_dn, cpu_stop_n, clkreq_n[1:0]}; idle is "nothing asserted"
    localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0111;

    logic [PIN_W-1:0] pin_raw;
    logic [PIN_W-1:0] pin_s;
    logic             pd_s;
    logic             stop_act;
    logic [1:0]       req_act;

    assign pin_raw = {pwr_dn, cpu_stop_n, clkreq_n};

    clkout_gate_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .IDLE   (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    assign pd_s     = pin_s[3];
    assign stop_act = ~pin_s[2];
    assign req_act  = ~pin_s[1:0];

    // Processor group lanes
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        lane_mode_e want;
        assign want = resolve_mode(cpu_en[i], pd_s, cpu_pd_float,
                                   stop_act & cpu_stop_mask[i], cpu_stop_float);
        clkout_gate_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .lvl  (cpu_lvl[i]),
            .want (want),
            .run  (cpu_run[i]),
            .oe   (cpu_oe[i]),
            .pt   (cpu_t[i]),
            .pc   (cpu_c[i])
        );
    end

    // Serial-link group lanes: either request pin may halt, each under its own mask
    for (genvar j = 0; j < NSRC; j++) begin : g_src
        lane_mode_e want;
        logic       halted;
        assign halted = (req_act[0] & req0_mask[j]) | (req_act[1] & req1_mask[j]);
        assign want   = resolve_mode(src_en[j], pd_s, src_pd_float, halted, req_float);
        clkout_gate_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .lvl  (src_lvl[j]),
            .want (want),
            .run  (src_run[j]),
            .oe   (src_oe[j]),
            .pt   (src_t[j]),
            .pc   (src_c[j])
        );
    end
endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk #(
    parameter int NCPU = 3,
    parameter int NSRC = 6
) (
    input logic            clk,
    input logic            rst,
    input logic [NCPU-1:0] cpu_lvl,
    input logic [NSRC-1:0] src_lvl,
    input logic [NCPU-1:0] cpu_en,
    input logic [NSRC-1:0] src_en,
    input logic [NCPU-1:0] cpu_stop_mask,
    input logic [NSRC-1:0] req0_mask,
    input logic [NSRC-1:0] req1_mask,
    input logic            cpu_stop_float,
    input logic            req_float,
    input logic            cpu_pd_float,
    input logic            src_pd_float,
    input logic            pd_s,
    input logic            stop_act,
    input logic [1:0]      req_act,
    input logic [NCPU-1:0] cpu_run,
    input logic [NCPU-1:0] cpu_oe,
    input logic [NCPU-1:0] cpu_t,
    input logic [NCPU-1:0] cpu_c,
    input logic [NSRC-1:0] src_run,
    input logic [NSRC-1:0] src_oe,
    input logic [NSRC-1:0] src_t,
    input logic [NSRC-1:0] src_c
);
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu_chk
        assert_cpu_disable_R2: assert property (@(posedge clk) disable iff (rst)
            (!cpu_en[i] && !cpu_lvl[i]) |=> (!cpu_oe[i] && !cpu_run[i]));

        assert_cpu_stop_mode_R4: assert property (@(posedge clk) disable iff (rst)
            (cpu_en[i] && !pd_s && stop_act && cpu_stop_mask[i] && !cpu_lvl[i])
            |=> (!cpu_run[i] && (cpu_oe[i] == !$past(cpu_stop_float))));

        assert_cpu_free_R3: assert property (@(posedge clk) disable iff (rst)
            (cpu_en[i] && !pd_s && !(stop_act && cpu_stop_mask[i]) && !cpu_lvl[i])
            |=> cpu_run[i]);

        assert_cpu_pd_R7: assert property (@(posedge clk) disable iff (rst)
            (cpu_en[i] && pd_s && !cpu_lvl[i])
            |=> (!cpu_run[i] && (cpu_oe[i] == !$past(cpu_pd_float))));

        assert_cpu_hold_R8: assert property (@(posedge clk) disable iff (rst)
            cpu_lvl[i] |=> ($stable(cpu_run[i]) && $stable(cpu_oe[i])));

        assert_cpu_levels_R9: assert property (@(posedge clk) disable iff (rst)
            cpu_run[i] ? (cpu_t[i] == cpu_lvl[i] && cpu_c[i] != cpu_lvl[i])
                       : (!cpu_t[i] && cpu_c[i]));
    end

    for (genvar j = 0; j < NSRC; j++) begin : g_src_chk
        assert_src_disable_R2: assert property (@(posedge clk) disable iff (rst)
            (!src_en[j] && !src_lvl[j]) |=> (!src_oe[j] && !src_run[j]));

        assert_src_req_R6: assert property (@(posedge clk) disable iff (rst)
            (src_en[j] && !pd_s && !src_lvl[j] &&
             ((req_act[0] && req0_mask[j]) || (req_act[1] && req1_mask[j])))
            |=> (!src_run[j] && (src_oe[j] == !$past(req_float))));

        assert_src_free_R5: assert property (@(posedge clk) disable iff (rst)
            (src_en[j] && !pd_s && !src_lvl[j] &&
             !((req_act[0] && req0_mask[j]) || (req_act[1] && req1_mask[j])))
            |=> src_run[j]);

        assert_src_pd_R7: assert property (@(posedge clk) disable iff (rst)
            (src_en[j] && pd_s && !src_lvl[j])
            |=> (!src_run[j] && (src_oe[j] == !$past(src_pd_float))));

        assert_src_hold_R8: assert property (@(posedge clk) disable iff (rst)
            src_lvl[j] |=> ($stable(src_run[j]) && $stable(src_oe[j])));

        assert_src_levels_R9: assert property (@(posedge clk) disable iff (rst)
            src_run[j] ? (src_t[j] == src_lvl[j] && src_c[j] != src_lvl[j])
                       : (!src_t[j] && src_c[j]));
    end
endmodule

bind clkout_gate_ctrl clkout_gate_chk #(
    .NCPU (NCPU),
    .NSRC (NSRC)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_lvl        (cpu_lvl),
    .src_lvl        (src_lvl),
    .cpu_en         (cpu_en),
    .src_en         (src_en),
    .cpu_stop_mask  (cpu_stop_mask),
    .req0_mask      (req0_mask),
    .req1_mask      (req1_mask),
    .cpu_stop_float (cpu_stop_float),
    .req_float      (req_float),
    .cpu_pd_float   (cpu_pd_float),
    .src_pd_float   (src_pd_float),
    .pd_s           (pd_s),
    .stop_act       (stop_act),
    .req_act        (req_act),
    .cpu_run        (cpu_run),
    .cpu_oe         (cpu_oe),
    .cpu_t          (cpu_t),
    .cpu_c          (cpu_c),
    .src_run        (src_run),
    .src_oe         (src_oe),
    .src_t          (src_t),
    .src_c          (src_c)
);

// File: tb/clkout_gate_ctrl_test.sv
module clkout_gate_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 3;
    localparam int NSRC = 6;
    localparam int NV   = 10;

    typedef struct packed {
        logic            pd;
        logic            stop_n;
        logic [1:0]      req_n;
        logic            csf;
        logic            rf;
        logic            cpf;
        logic            spf;
        logic [NCPU-1:0] cmask;
        logic [NSRC-1:0] m0;
        logic [NSRC-1:0] m1;
        logic [NCPU-1:0] cen;
        logic [NSRC-1:0] sen;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 6'h00, 6'h00, 3'b111, 6'h3F},
        '{1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101, 6'h00, 6'h00, 3'b111, 6'h3F},
        '{1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 3'b111, 6'h00, 6'h00, 3'b111, 6'h3F},
        '{1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 6'h03, 6'h30, 3'b111, 6'h3F},
        '{1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 3'b111, 6'h03, 6'h30, 3'b111, 6'h3F},
        '{1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 6'h00, 6'h00, 3'b111, 6'h3F},
        '{1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 6'h3F, 6'h3F, 3'b111, 6'h3F},
        '{1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 6'h00, 6'h00, 3'b111, 6'h3F},
        '{1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 6'h3F, 6'h3F, 3'b010, 6'h2A},
        '{1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 6'h00, 6'h00, 3'b100, 6'h01}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic [NCPU-1:0] cpu_lvl, cpu_en, cpu_stop_mask;
    logic [NSRC-1:0] src_lvl, src_en, req0_mask, req1_mask;
    logic            cpu_stop_float, req_float, cpu_pd_float, src_pd_float;
    logic            cpu_stop_n, pwr_dn;
    logic [1:0]      clkreq_n;
    logic [NCPU-1:0] cpu_run, cpu_oe, cpu_t, cpu_c;
    logic [NSRC-1:0] src_run, src_oe, src_t, src_c;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkout_gate_ctrl #(.NCPU(NCPU), .NSRC(NSRC)) uut (
        .clk(clk), .rst(rst),
        .cpu_lvl(cpu_lvl), .src_lvl(src_lvl),
        .cpu_en(cpu_en), .src_en(src_en),
        .cpu_stop_mask(cpu_stop_mask), .req0_mask(req0_mask), .req1_mask(req1_mask),
        .cpu_stop_float(cpu_stop_float), .req_float(req_float),
        .cpu_pd_float(cpu_pd_float), .src_pd_float(src_pd_float),
        .cpu_stop_n(cpu_stop_n), .clkreq_n(clkreq_n), .pwr_dn(pwr_dn),
        .cpu_run(cpu_run), .cpu_oe(cpu_oe), .cpu_t(cpu_t), .cpu_c(cpu_c),
        .src_run(src_run), .src_oe(src_oe), .src_t(src_t), .src_c(src_c)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        pwr_dn = v.pd;  cpu_stop_n = v.stop_n;  clkreq_n = v.req_n;
        cpu_stop_float = v.csf;  req_float = v.rf;
        cpu_pd_float = v.cpf;    src_pd_float = v.spf;
        cpu_stop_mask = v.cmask; req0_mask = v.m0; req1_mask = v.m1;
        cpu_en = v.cen;          src_en = v.sen;
    endtask

    function automatic string tag_of(input int v);
        case (v)
            0: return "R3 R5 baseline";
            1: return "R3 R4 partial mask";
            2: return "R4 float";
            3: return "R5 R6 pin0";
            4: return "R5 R6 pin1 float";
            5: return "R5 masks clear";
            6: return "R7 cpu driven src float";
            7: return "R7 cpu float src driven";
            8: return "R2 enables";
            default: return "R2 R7 enable over pd";
        endcase
    endfunction

    // Expected {run, oe} per group derived from the priority in the requirements
    task automatic expect_of(input vec_t v,
                             output logic [NCPU-1:0] crun, output logic [NCPU-1:0] coe,
                             output logic [NSRC-1:0] srun, output logic [NSRC-1:0] soe);
        for (int i = 0; i < NCPU; i++) begin
            if (!v.cen[i])                       begin crun[i] = 0; coe[i] = 0; end
            else if (v.pd)                       begin crun[i] = 0; coe[i] = !v.cpf; end
            else if (!v.stop_n && v.cmask[i])    begin crun[i] = 0; coe[i] = !v.csf; end
            else                                 begin crun[i] = 1; coe[i] = 1; end
        end
        for (int j = 0; j < NSRC; j++) begin
            if (!v.sen[j])                       begin srun[j] = 0; soe[j] = 0; end
            else if (v.pd)                       begin srun[j] = 0; soe[j] = !v.spf; end
            else if ((!v.req_n[0] && v.m0[j]) || (!v.req_n[1] && v.m1[j]))
                                                 begin srun[j] = 0; soe[j] = !v.rf; end
            else                                 begin srun[j] = 1; soe[j] = 1; end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NCPU-1:0] ecr, eco;
        logic [NSRC-1:0] esr, eso;
        rst = 1'b1;
        cpu_lvl = '0;
        src_lvl = '0;
        drive(VEC[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset cpu_run", 32'(cpu_run), 32'h7);
        check("R1 reset src_oe", 32'(src_oe), 32'h3F);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 after reset run", 32'({cpu_run, src_run}), 32'h1FF);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            drive(VEC[v]);
            repeat (4) @(posedge clk);
            @(negedge clk);
            expect_of(VEC[v], ecr, eco, esr, eso);
            check({tag_of(v), " cpu_run"}, 32'(cpu_run), 32'(ecr));
            check({tag_of(v), " cpu_oe"},  32'(cpu_oe),  32'(eco));
            check({tag_of(v), " src_run"}, 32'(src_run), 32'(esr));
            check({tag_of(v), " src_oe"},  32'(src_oe),  32'(eso));
        end

        // R10: pin latency through the synchroniser
        drive(VEC[0]);
        repeat (4) @(posedge clk);
        @(negedge clk);
        cpu_stop_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 not yet after two edges", 32'(cpu_run), 32'h7);
        @(posedge clk);
        @(negedge clk);
        check("R10 halted after third edge", 32'(cpu_run), 32'h0);
        check("R9 parked true low", 32'(cpu_t), 32'h0);
        check("R9 parked complement high", 32'(cpu_c), 32'h7);

        // R8: a restart waits for the low phase
        drive(VEC[0]);
        cpu_lvl = '1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R8 held while lvl high", 32'(cpu_run), 32'h0);
        check("R9 parked true with lvl high", 32'(cpu_t), 32'h0);
        cpu_lvl = '0;
        @(posedge clk);
        @(negedge clk);
        check("R8 restart at low phase", 32'(cpu_run), 32'h7);
        cpu_lvl = '1;
        #1;
        check("R9 running true follows lvl", 32'(cpu_t), 32'h7);
        check("R9 running complement inverted", 32'(cpu_c), 32'h0);

        // R8: a stop during a high phase waits, then lands on the low phase
        cpu_stop_n = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R8 stop held off while high", 32'(cpu_run), 32'h7);
        cpu_lvl = 3'b010;
        @(posedge clk);
        @(negedge clk);
        check("R8 only low-phase lanes stop", 32'(cpu_run), 32'h2);

        // R2: disable with pins idle and lvl low
        cpu_lvl = '0;
        drive(VEC[0]);
        src_en = 6'h0F;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R2 disabled src float", 32'({src_run, src_oe}), 32'({6'h0F, 6'h0F}));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule